// File: doc/BRIEF.md
# Gated Programmable Sample-Clock Divider

The block derives a slow clock for audio sampling from a fast input clock. A divide code sets the output period in input cycles, and the code value zero switches the output off instead of selecting a ratio. An optional high-time code sets how many input cycles of each period the output stays high, so the same block can drive a frame or left/right clock with an unequal duty cycle. When the high-time code is left out at build time, the output runs as close to 50% duty as the ratio allows.

The output is a register in the input clock domain. Both codes are captured into shadow registers only on the last cycle of a period, or when the divider starts from the gated state. A code can therefore be rewritten at any time without producing a short pulse or a shortened period.

Top module: `smpclk_div`

## Requirements
- R1: After a synchronous reset, `clk_o` is 0 and the period counter is 0. The first period starts with its high phase only after a nonzero divide code is sampled.
- R2: While the divider is gated (divide code 0 captured, or never started), `clk_o` is held at 0.
- R3: With a captured nonzero divide code `d`, the output period is `d+1` input cycles. The smallest ratio is 2, from code 1.
- R4: When `HAS_HI=1`, each period begins with a high phase of `h+1` input cycles, where `h` is the captured high-time code, followed by a low phase for the rest of the period.
- R5: When `HAS_HI=1` and the high-time code is greater than or equal to the divide code, it is treated as equal to the divide code, and the output stays constantly high.
- R6: When `HAS_HI=0`, the high phase lasts floor((d+1)/2) cycles. For an odd ratio, the low phase is therefore the longer one.
- R7: A change of the divide or high-time code during a period has no effect until that period has ended. Codes are sampled on the last cycle of the period.
- R8: Leaving the gated state: in the cycle after the edge at which a nonzero divide code is first sampled, `clk_o` is 1 and a fresh period has begun.
- R9: A divide code of 0 written during a period gates the output only at the end of that period. From the next cycle on, `clk_o` is 0.
- R10: The largest code, 2^CODE_W−1, gives a division by 2^CODE_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_i | input | 1 | Synchronous reset, active high |
| div_code_i | input | CODE_W | Divide code; 0 gates the output, d>0 divides by d+1 |
| hi_code_i | input | CODE_W | High-time code, high for h+1 cycles; ignored when HAS_HI=0 |
| clk_o | output | 1 | Divided clock, registered |

## Verification
The hardest case to reach is a code change that lands exactly on the last cycle of a period, as opposed to one cycle earlier or later. This is what decides whether the old or the new ratio governs the next period. Random stimulus changes the codes at random cycles over thousands of cycles, using a narrow code range so that boundary hits are frequent. A cycle-by-cycle reference model in the bench compares every output sample. Directed cases then target a mid-period rewrite, a mid-period gate, the largest code and an out-of-range high-time code.

// File: rtl/smpclk_pkg.sv
package smpclk_pkg;
   // length of the high phase for a captured divide/high code pair
   function automatic int unsigned high_len(input int unsigned div,
                                            input int unsigned hi,
                                            input bit has_hi);
      int unsigned clip;
      if (has_hi) begin
         clip = (hi > div) ? div : hi;
         return clip + 1;
      end
      return (div + 1) / 2;
   endfunction
endpackage

// File: rtl/smpclk_gate_ctl.sv
module smpclk_gate_ctl #(
   parameter int CODE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [CODE_W-1:0] div_code_i,
   input  logic              wrap_i,
   output logic              active_q,
   output logic              active_d,
   output logic              reload_o
);
   logic code_nz, start, stop;

   always_comb begin
      code_nz  = |div_code_i;
      start    = !active_q && code_nz;
      stop     = active_q && wrap_i && !code_nz;
      reload_o = start || (active_q && wrap_i && code_nz);
      active_d = start || (active_q && !stop);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) active_q <= 1'b0;
      else       active_q <= active_d;
   end
endmodule

// File: rtl/smpclk_period_ctr.sv
module smpclk_period_ctr #(
   parameter int CODE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              active_q,
   input  logic              active_d,
   input  logic              reload_i,
   input  logic [CODE_W-1:0] div_code_i,
   input  logic [CODE_W-1:0] hi_code_i,
   output logic [CODE_W-1:0] cnt_q,
   output logic [CODE_W-1:0] div_q,
   output logic [CODE_W-1:0] cnt_d,
   output logic [CODE_W-1:0] div_d,
   output logic [CODE_W-1:0] hi_d,
   output logic              wrap_o
);
   logic [CODE_W-1:0] hi_q;

   always_comb begin
      wrap_o = active_q && (cnt_q == div_q);
      div_d  = div_q;
      hi_d   = hi_q;
      if (!active_d) begin
         cnt_d = '0;
      end else if (reload_i) begin
         cnt_d = '0;
         div_d = div_code_i;
         hi_d  = hi_code_i;
      end else begin
         cnt_d = cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= '0;
         div_q <= '0;
         hi_q  <= '0;
      end else begin
         cnt_q <= cnt_d;
         div_q <= div_d;
         hi_q  <= hi_d;
      end
   end
endmodule

// File: rtl/smpclk_wave.sv
module smpclk_wave #(
   parameter int CODE_W = 8,
   parameter bit HAS_HI = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              active_d,
   input  logic [CODE_W-1:0] cnt_d,
   input  logic [CODE_W-1:0] div_d,
   input  logic [CODE_W-1:0] hi_d,
   output logic              clk_o
);
   localparam int LEN_W = CODE_W + 1;
   logic [LEN_W-1:0] hlen;

   generate
      if (HAS_HI) begin : g_duty
         logic [CODE_W-1:0] clip;
         always_comb begin
            clip = (hi_d > div_d) ? div_d : hi_d;
            hlen = {1'b0, clip} + 1'b1;
         end
      end else begin : g_half
         always_comb hlen = ({1'b0, div_d} + 1'b1) >> 1;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) clk_o <= 1'b0;
      else       clk_o <= active_d && ({1'b0, cnt_d} < hlen);
   end
endmodule

// File: rtl/smpclk_div.sv
module smpclk_div #(
   parameter int CODE_W = 8,
   parameter bit HAS_HI = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [CODE_W-1:0] div_code_i,
   input  logic [CODE_W-1:0] hi_code_i,
   output logic              clk_o
);
   generate
      if (CODE_W < 1 || CODE_W > 16) begin : g_bad_width
         $error("smpclk_div: CODE_W must be 1..16");
      end
   endgenerate

   logic              active_q, active_d, reload, wrap;
   logic [CODE_W-1:0] cnt_q, div_q, cnt_d, div_d, hi_d;

   smpclk_gate_ctl #(.CODE_W(CODE_W)) gate_i (
      .clk_i(clk_i), .rst_i(rst_i), .div_code_i(div_code_i),
      .wrap_i(wrap), .active_q(active_q), .active_d(active_d),
      .reload_o(reload));

   smpclk_period_ctr #(.CODE_W(CODE_W)) ctr_i (
      .clk_i(clk_i), .rst_i(rst_i), .active_q(active_q),
      .active_d(active_d), .reload_i(reload), .div_code_i(div_code_i),
      .hi_code_i(hi_code_i), .cnt_q(cnt_q), .div_q(div_q),
      .cnt_d(cnt_d), .div_d(div_d), .hi_d(hi_d), .wrap_o(wrap));

   smpclk_wave #(.CODE_W(CODE_W), .HAS_HI(HAS_HI)) wave_i (
      .clk_i(clk_i), .rst_i(rst_i), .active_d(active_d),
      .cnt_d(cnt_d), .div_d(div_d), .hi_d(hi_d), .clk_o(clk_o));
endmodule

// File: rtl/smpclk_div_chk.sv
module smpclk_div_chk #(
   parameter int CODE_W = 8
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic [CODE_W-1:0] div_code_i,
   input logic              clk_o,
   input logic              active_q,
   input logic [CODE_W-1:0] cnt_q,
   input logic [CODE_W-1:0] div_q
);
   a_r1_reset_state: assert property (@(posedge clk_i)
      rst_i |=> (!clk_o && cnt_q == '0));

   a_r2_gated_low: assert property (@(posedge clk_i) disable iff (rst_i)
      !active_q |-> (!clk_o && cnt_q == '0));

   a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (rst_i)
      active_q |-> (cnt_q <= div_q && div_q != '0));

   a_r7_hold_mid_period: assert property (@(posedge clk_i) disable iff (rst_i)
      (active_q && cnt_q != div_q) |=> $stable(div_q));

   a_r8_start_high: assert property (@(posedge clk_i) disable iff (rst_i)
      (!active_q && div_code_i != '0) |=> (clk_o && cnt_q == '0));

   a_r9_gate_at_end: assert property (@(posedge clk_i) disable iff (rst_i)
      (active_q && cnt_q == div_q && div_code_i == '0) |=> !clk_o);
endmodule

bind smpclk_div smpclk_div_chk #(.CODE_W(CODE_W)) chk_i (
   .clk_i(clk_i), .rst_i(rst_i), .div_code_i(div_code_i), .clk_o(clk_o),
   .active_q(active_q), .cnt_q(cnt_q), .div_q(div_q));

// File: tb/smpclk_div_tb_top.sv
module smpclk_div_tb_top;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] dcode = '0;
   logic [W-1:0] hcode = '0;
   logic         out_a, out_b;
   int           n_chk = 0, n_fail = 0;
   bit           model_on = 1'b0;

   always #2.5 clk = ~clk;

   smpclk_div #(.CODE_W(W), .HAS_HI(1'b1)) dut_i (
      .clk_i(clk), .rst_i(rst), .div_code_i(dcode), .hi_code_i(hcode), .clk_o(out_a));
   smpclk_div #(.CODE_W(W), .HAS_HI(1'b0)) dut50_i (
      .clk_i(clk), .rst_i(rst), .div_code_i(dcode), .hi_code_i(hcode), .clk_o(out_b));

   // expected high length from R4/R5/R6
   function automatic int exp_high(int d, int h, bit has_hi);
      if (has_hi) return ((h > d) ? d : h) + 1;
      return (d + 1) / 2;
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model of the period sequence (R2,R3,R7,R8,R9)
   bit m_run; int m_cnt, m_div, m_hi; bit m_start;
   always @(posedge clk) begin
      if (rst) begin
         m_run = 0; m_cnt = 0; m_div = 0; m_hi = 0; m_start = 0;
      end else begin
         m_start = 0;
         if (!m_run) begin
            if (dcode != 0) begin
               m_run = 1; m_cnt = 0; m_div = dcode; m_hi = hcode; m_start = 1;
            end
         end else if (m_cnt == m_div) begin
            if (dcode == 0) begin m_run = 0; m_cnt = 0; end
            else begin m_cnt = 0; m_div = dcode; m_hi = hcode; end
         end else m_cnt++;
      end
   end

   always @(negedge clk) begin
      if (model_on) begin
         bit ea, eb;
         string tg;
         ea = m_run && (m_cnt < exp_high(m_div, m_hi, 1'b1));
         eb = m_run && (m_cnt < exp_high(m_div, m_hi, 1'b0));
         tg = !m_run ? "R2" : (m_start ? "R8" : "R4");
         chk(out_a == ea, tg, out_a, ea);
         chk(out_b == eb, m_run ? "R6" : "R2", out_b, eb);
      end
   end

   task automatic wait_rise_a();
      bit prev;
      prev = out_a;
      forever begin
         @(negedge clk);
         if (out_a && !prev) break;
         prev = out_a;
      end
   endtask

   // cycles from a rising edge of out_a to the next one
   task automatic period_a(output int p);
      bit prev;
      p = 0;
      prev = 1'b1;
      forever begin
         @(negedge clk);
         p++;
         if (out_a && !prev) break;
         prev = out_a;
      end
   endtask

   task automatic high_count(input bit which, input int cycles, output int hc);
      hc = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         hc += which ? int'(out_b) : int'(out_a);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int p, hc;
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(out_a == 0, "R1", out_a, 0);
      chk(out_b == 0, "R1", out_b, 0);
      model_on = 1'b1;
      repeat (5) @(negedge clk);
      chk(out_a == 0, "R2", out_a, 0);

      // R8: start high one cycle after a nonzero code is seen
      dcode = 3; hcode = 1;
      @(negedge clk);
      chk(out_a == 1, "R8", out_a, 1);
      chk(out_b == 1, "R8", out_b, 1);

      // R3: period per code, including the minimum ratio
      foreach (dcode[i]) ;
      for (int c = 1; c <= 7; c += 3) begin
         dcode = c; hcode = 0;
         wait_rise_a(); wait_rise_a();
         period_a(p);
         chk(p == c + 1, "R3", p, c + 1);
      end

      // R4: high phase hi+1
      dcode = 5; hcode = 1;
      wait_rise_a(); wait_rise_a();
      high_count(1'b0, 6, hc);
      chk(hc == 2, "R4", hc, 2);

      // R6: odd ratio 5 on the half-duty variant
      dcode = 4;
      wait_rise_a(); wait_rise_a();
      @(negedge clk); @(negedge clk);
      high_count(1'b1, 5, hc);
      chk(hc == 2, "R6", hc, exp_high(4, 0, 1'b0));

      // R5: hi beyond divide code gives constant high
      dcode = 4; hcode = 9;
      wait_rise_a(); repeat (10) @(negedge clk);
      high_count(1'b0, 10, hc);
      chk(hc == 10, "R5", hc, 10);

      // R10: largest code
      dcode = '1; hcode = 0;
      wait_rise_a(); wait_rise_a();
      period_a(p);
      chk(p == (1 << W), "R10", p, 1 << W);

      // R7: mid-period rewrite does not shorten the running period
      dcode = 7; hcode = 3;
      wait_rise_a(); wait_rise_a();
      @(negedge clk);
      dcode = 1;
      p = 1;
      begin
         bit prev;
         prev = out_a;
         forever begin
            @(negedge clk);
            p++;
            if (out_a && !prev) break;
            prev = out_a;
         end
      end
      chk(p == 8, "R7", p, 8);

      // R9: gating takes effect at the period end
      dcode = 7; hcode = 3;
      wait_rise_a(); wait_rise_a();
      @(negedge clk);
      dcode = 0;
      repeat (7) @(negedge clk);
      high_count(1'b0, 20, hc);
      chk(hc == 0, "R9", hc, 0);

      // random stretch, narrow codes for frequent boundary hits
      for (int k = 0; k < 4000; k++) begin
         if ($urandom_range(0, 5) == 0) dcode = W'($urandom_range(0, 6));
         if ($urandom_range(0, 5) == 0) hcode = W'($urandom_range(0, 8));
         @(negedge clk);
      end

      // R1 again: reset in mid-run
      dcode = 2;
      repeat (3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(out_a == 0, "R1", out_a, 0);
      rst = 1'b0;
      @(negedge clk);
      chk(out_a == 1, "R8", out_a, 1);
      repeat (10) @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule